// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a synchronous request port and an external asynchronous static RAM of 2^18 sixteen-bit words. A client presents one transfer at a time with a valid/ready handshake: an 18-bit word address, a write flag, a 16-bit write word and two active-high byte enables. The controller turns each transfer into a correctly timed asynchronous cycle on the memory pins. These pins are active-low chip select, write enable, output enable, and lower and upper byte selects, plus the address bus. The bidirectional data bus is split into separate out, in and drive-enable signals.

Every phase length is fixed when the block is built. The nanosecond minimums of the memory are divided by the clock period parameter and rounded up, with a floor of one cycle. Writes are controlled by write enable: the write-enable pulse opens and closes the write, while chip select stays low for the whole write cycle. Reads hold output enable low for the full read cycle and sample the bus at the closing edge. The sampled word is returned with a one-cycle valid pulse. After every read, one idle cycle passes before the controller may drive the bus again. The data bus is never driven while the memory is deselected.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, req_ready is 1, sram_cs_n, sram_we_n, sram_oe_n, sram_lb_n and sram_ub_n are 1, and dq_oe and rsp_valid are 0.
- R2: A read with at least one enable set holds sram_cs_n, sram_oe_n and the selected lane selects low, with sram_we_n high. This lasts for ceil(T_RC_NS/CLK_NS) cycles (floor 1), which is 11 cycles at the defaults.
- R3: A write with at least one enable set holds sram_we_n, sram_cs_n and the selected lane selects low for WP cycles. WP is the largest of ceil(60/CLK_NS), ceil(70/CLK_NS) and ceil(35/CLK_NS), which is 9 at the defaults. sram_we_n then goes high while chip select and the lanes stay low for max(ceil(85/CLK_NS)-WP, 1) cycles, which is 2. Chip select is low for 11 cycles in total.
- R4: req_be[0] drives sram_lb_n low and covers data bits 7:0. req_be[1] drives sram_ub_n low and covers bits 15:8. The address of the transfer appears on sram_addr. A write that enables one lane leaves the other byte of the word unchanged.
- R5: Read data is sampled from dq_in at the clock edge that ends the read phase. rsp_valid is high for exactly one cycle after that edge. In rsp_data, the bits of each lane whose enable was 0 read as 0.
- R6: dq_oe is high only in cycles where sram_we_n is low. sram_oe_n is high in every cycle where dq_oe is high.
- R7: After each read, one cycle follows with chip select, output enable and both lane selects high. dq_oe stays low in the cycle after sram_oe_n rises.
- R8: req_ready is high only while no cycle is in progress. A request is taken at the edge where req_valid and req_ready are both high. After a read is taken, req_ready is low for RD+1 cycles (12). After a write is taken, it is low for WP plus tail cycles (11). req_ready is never high while sram_cs_n is low.
- R9: A transfer with req_be = 00 takes its normal number of cycles but drives no strobe low. The memory is unchanged, and such a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Controller idle, request taken this edge if valid |
| req_addr | input | 18 | Word address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_data | output | 16 | Read word, disabled lanes zero |
| sram_addr | output | 18 | Memory address bus |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_lb_n | output | 1 | Low byte select, active low |
| sram_ub_n | output | 1 | High byte select, active low |
| dq_out | output | 16 | Data to memory |
| dq_oe | output | 1 | Data bus drive enable |
| dq_in | input | 16 | Data from memory |

## Verification
The bench builds the block with its default parameters: an 8 ns clock and the 85/60/70/35 ns minimums. Write enable is set by the 70 ns select-to-end limit (9 cycles) rather than the pulse width, and the write tail is two cycles, so the rounding and the maximum in the phase formulas can both be observed.

The memory model withholds valid data until 11 cycles of output enable have elapsed and returns garbage on deselected lanes. An early sample or a missing lane mask therefore shows up as a data miscompare.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    localparam int SRAM_AW = 18;
    localparam int SRAM_DW = 16;
    localparam int LANES   = SRAM_DW / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_GAP,
        ST_WP,
        ST_WT
    } phase_e;

    typedef struct packed {
        logic [SRAM_AW-1:0] addr;
        logic               write;
        logic [SRAM_DW-1:0] wdata;
        logic [LANES-1:0]   be;
    } xfer_t;

    // cycles needed to cover a nanosecond minimum, never fewer than one
    function automatic int ns2cyc(input int ns, input int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_lane_seq.sv
module sram_lane_seq
    import sram_ctl_pkg::*;
#(
    parameter int RD_CYC   = 11,
    parameter int WP_CYC   = 9,
    parameter int TAIL_CYC = 2,
    parameter int CNT_W    = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  xfer_t              req_in,
    output logic               req_ready,
    output logic               cap,
    output logic [LANES-1:0]   cur_be,
    output logic               cs_n,
    output logic               we_n,
    output logic               oe_n,
    output logic [LANES-1:0]   sel_n,
    output logic [SRAM_AW-1:0] addr,
    output logic [SRAM_DW-1:0] dq_out,
    output logic               dq_oe
);
    phase_e           st_q, st_d;
    xfer_t            req_q, req_d;
    logic             load;
    logic [CNT_W-1:0] load_val;
    logic             done;
    logic             any_d;
    logic             live_d;

    sram_phase_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .done     (done)
    );

    assign req_ready = (st_q == ST_IDLE);
    assign cur_be    = req_q.be;

    always_comb begin
        st_d     = st_q;
        req_d    = req_q;
        load     = 1'b0;
        load_val = '0;
        cap      = 1'b0;
        case (st_q)
            ST_IDLE: begin
                if (req_valid) begin
                    req_d = req_in;
                    load  = 1'b1;
                    if (req_in.write) begin
                        st_d     = ST_WP;
                        load_val = CNT_W'(WP_CYC - 1);
                    end else begin
                        st_d     = ST_RD;
                        load_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_RD: begin
                if (done) begin
                    st_d = ST_GAP;
                    cap  = 1'b1;
                end
            end
            ST_GAP: st_d = ST_IDLE;
            ST_WP: begin
                if (done) begin
                    st_d     = ST_WT;
                    load     = 1'b1;
                    load_val = CNT_W'(TAIL_CYC - 1);
                end
            end
            ST_WT: begin
                if (done) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign any_d  = |req_d.be;
    assign live_d = any_d && (st_d inside {ST_RD, ST_WP, ST_WT});

    // pins come straight from flops, computed from the next phase
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            req_q  <= '0;
            cs_n   <= 1'b1;
            we_n   <= 1'b1;
            oe_n   <= 1'b1;
            sel_n  <= '1;
            dq_oe  <= 1'b0;
            addr   <= '0;
            dq_out <= '0;
        end else begin
            st_q   <= st_d;
            req_q  <= req_d;
            cs_n   <= !live_d;
            we_n   <= !(any_d && st_d == ST_WP);
            oe_n   <= !(any_d && st_d == ST_RD);
            sel_n  <= live_d ? ~req_d.be : '1;
            dq_oe  <= any_d && (st_d == ST_WP);
            addr   <= req_d.addr;
            dq_out <= req_d.wdata;
        end
    end

    assert_drive_only_in_write_R6: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (!we_n && oe_n));

    assert_write_needs_select_R3: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!cs_n && !(&sel_n) && oe_n));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture
    import sram_ctl_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cap,
    input  logic [LANES-1:0]   be,
    input  logic [SRAM_DW-1:0] dq_in,
    output logic               rsp_valid,
    output logic [SRAM_DW-1:0] rsp_data
);
    logic [SRAM_DW-1:0] masked;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign masked[g*8 +: 8] = be[g] ? dq_in[g*8 +: 8] : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= cap;
            if (cap) rsp_data <= masked;
        end
    end

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS  = 8,
    parameter int T_RC_NS = 85,
    parameter int T_WC_NS = 85,
    parameter int T_WP_NS = 60,
    parameter int T_AW_NS = 70,
    parameter int T_DW_NS = 35
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [SRAM_AW-1:0]  req_addr,
    input  logic                req_write,
    input  logic [SRAM_DW-1:0]  req_wdata,
    input  logic [LANES-1:0]    req_be,
    output logic                rsp_valid,
    output logic [SRAM_DW-1:0]  rsp_data,
    output logic [SRAM_AW-1:0]  sram_addr,
    output logic                sram_cs_n,
    output logic                sram_we_n,
    output logic                sram_oe_n,
    output logic                sram_lb_n,
    output logic                sram_ub_n,
    output logic [SRAM_DW-1:0]  dq_out,
    output logic                dq_oe,
    input  logic [SRAM_DW-1:0]  dq_in
);
    localparam int RD_CYC   = ns2cyc(T_RC_NS, CLK_NS);
    localparam int WP_CYC   = imax(imax(ns2cyc(T_WP_NS, CLK_NS), ns2cyc(T_AW_NS, CLK_NS)),
                                   ns2cyc(T_DW_NS, CLK_NS));
    localparam int WC_CYC   = ns2cyc(T_WC_NS, CLK_NS);
    localparam int TAIL_CYC = imax(WC_CYC - WP_CYC, 1);
    localparam int CNT_W    = $clog2(imax(RD_CYC, imax(WP_CYC, TAIL_CYC)) + 1);

    xfer_t            req_in;
    logic             cap;
    logic [LANES-1:0] cur_be;
    logic [LANES-1:0] sel_n;

    assign req_in = '{addr: req_addr, write: req_write, wdata: req_wdata, be: req_be};

    sram_lane_seq #(
        .RD_CYC   (RD_CYC),
        .WP_CYC   (WP_CYC),
        .TAIL_CYC (TAIL_CYC),
        .CNT_W    (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_in    (req_in),
        .req_ready (req_ready),
        .cap       (cap),
        .cur_be    (cur_be),
        .cs_n      (sram_cs_n),
        .we_n      (sram_we_n),
        .oe_n      (sram_oe_n),
        .sel_n     (sel_n),
        .addr      (sram_addr),
        .dq_out    (dq_out),
        .dq_oe     (dq_oe)
    );

    assign sram_lb_n = sel_n[0];
    assign sram_ub_n = sel_n[1];

    sram_rd_capture u_cap (
        .clk       (clk),
        .rst       (rst),
        .cap       (cap),
        .be        (cur_be),
        .dq_in     (dq_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    // strobe width counters for the timing checks below
    logic [7:0] we_lo_cnt, oe_lo_cnt;
    always_ff @(posedge clk) begin
        if (rst) begin
            we_lo_cnt <= '0;
            oe_lo_cnt <= '0;
        end else begin
            we_lo_cnt <= sram_we_n ? 8'd0 : we_lo_cnt + 8'd1;
            oe_lo_cnt <= sram_oe_n ? 8'd0 : oe_lo_cnt + 8'd1;
        end
    end

    assert_we_width_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> (we_lo_cnt == 8'(WP_CYC)));

    assert_oe_width_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> (oe_lo_cnt == 8'(RD_CYC)));

    assert_rsp_pulse_R5: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    assert_dead_cycle_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_oe_n) |-> (sram_cs_n && !dq_oe) ##1 !dq_oe);

    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
        !sram_cs_n |-> !req_ready);

endmodule

// File: tb/sram_lane_ctrl_test.sv
`timescale 1ns/1ps
module sram_lane_ctrl_test;

    localparam int CLK    = 8;
    localparam int RD_EXP = (85 + CLK - 1) / CLK;
    localparam int WA     = (60 + CLK - 1) / CLK;
    localparam int WB     = (70 + CLK - 1) / CLK;
    localparam int WC     = (35 + CLK - 1) / CLK;
    localparam int WP_EXP = (WA > WB) ? ((WA > WC) ? WA : WC) : ((WB > WC) ? WB : WC);
    localparam int CS_EXP = (85 + CLK - 1) / CLK;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [17:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [17:0] sram_addr;
    logic        sram_cs_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n;
    logic [15:0] dq_out;
    logic        dq_oe;
    logic [15:0] dq_in = 16'hDEAD;

    always #4 clk = ~clk;

    sram_lane_ctrl uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write),
        .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n),
        .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    // behavioural memory with byte lanes and a slow read access
    logic [15:0] mem    [int];
    logic [15:0] shadow [int];
    bit          pend = 0;
    logic [17:0] p_addr;
    logic [15:0] p_data;
    logic [1:0]  p_lane;
    int          rd_cnt = 0;

    always @(negedge clk) begin
        logic [15:0] w;
        if (!sram_cs_n && !sram_we_n) begin
            pend   = 1;
            p_addr = sram_addr;
            p_data = dq_oe ? dq_out : 16'hxxxx;
            p_lane = {!sram_ub_n, !sram_lb_n};
        end else if (pend) begin
            w = mem.exists(int'(p_addr)) ? mem[int'(p_addr)] : 16'h0000;
            if (p_lane[0]) w[7:0]  = p_data[7:0];
            if (p_lane[1]) w[15:8] = p_data[15:8];
            mem[int'(p_addr)] = w;
            pend = 0;
        end
        if (!sram_cs_n && sram_we_n && !sram_oe_n) rd_cnt++;
        else rd_cnt = 0;
        if (rd_cnt >= RD_EXP) begin
            w = mem.exists(int'(sram_addr)) ? mem[int'(sram_addr)] : 16'h0000;
            dq_in = {sram_ub_n ? 8'h5A : w[15:8], sram_lb_n ? 8'hA5 : w[7:0]};
        end else begin
            dq_in = 16'hDEAD;
        end
    end

    // scoreboard and pin monitor
    logic [15:0] exp_q[$];
    int          exp_busy = 0;
    logic [1:0]  cur_be = '0;
    logic [17:0] cur_addr = '0;
    int          cs_falls = 0;
    int          we_cnt = 0, oe_cnt = 0, cs_cnt = 0, busy_cnt = 0;
    bit          prev_rv = 0, prev_oe_low = 0, prev_cs = 1;

    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                check(!prev_rv, "R5 valid pulse longer than one cycle", 32'(prev_rv), 32'd0);
                if (exp_q.size() == 0) check(0, "R5 unexpected read response", 32'(rsp_data), 32'hFFFFFFFF);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(rsp_data == e, "R5 read data", 32'(rsp_data), 32'(e));
                end
            end
            prev_rv = rsp_valid;

            if (!sram_we_n) we_cnt++;
            else if (we_cnt != 0) begin
                check(we_cnt == WP_EXP, "R3 write pulse cycles", 32'(we_cnt), 32'(WP_EXP));
                we_cnt = 0;
            end
            if (!sram_oe_n) oe_cnt++;
            else if (oe_cnt != 0) begin
                check(oe_cnt == RD_EXP, "R2 read strobe cycles", 32'(oe_cnt), 32'(RD_EXP));
                oe_cnt = 0;
            end
            if (!sram_cs_n) begin
                cs_cnt++;
                check({sram_ub_n, sram_lb_n} == ~cur_be, "R4 lane selects", 32'({sram_ub_n, sram_lb_n}), 32'(~cur_be));
                check(sram_addr == cur_addr, "R4 address bus", 32'(sram_addr), 32'(cur_addr));
                check(!req_ready, "R8 ready while selected", 32'(req_ready), 32'd0);
            end else if (cs_cnt != 0) begin
                check(cs_cnt == CS_EXP, "R3 select window cycles", 32'(cs_cnt), 32'(CS_EXP));
                cs_cnt = 0;
            end
            if (prev_cs && !sram_cs_n) cs_falls++;
            prev_cs = sram_cs_n;

            if (!req_ready) busy_cnt++;
            else if (busy_cnt != 0) begin
                check(busy_cnt == exp_busy, "R8 busy cycles", 32'(busy_cnt), 32'(exp_busy));
                busy_cnt = 0;
            end

            if (dq_oe) begin
                check(!sram_we_n && sram_oe_n, "R6 drive outside write", 32'({sram_we_n, sram_oe_n}), 32'b01);
                check(!prev_oe_low, "R7 drive right after read", 32'(prev_oe_low), 32'd0);
            end
            prev_oe_low = !sram_oe_n;
        end
    end

    task automatic do_op(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
        logic [15:0] cur;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_be    = be;
        cur_be    = be;
        cur_addr  = a;
        cur = shadow.exists(int'(a)) ? shadow[int'(a)] : 16'h0000;
        if (wr) begin
            if (be[0]) cur[7:0]  = d[7:0];
            if (be[1]) cur[15:8] = d[15:8];
            shadow[int'(a)] = cur;
        end else begin
            exp_q.push_back({be[1] ? cur[15:8] : 8'h00, be[0] ? cur[7:0] : 8'h00});
        end
        @(negedge clk);
        req_valid = 1'b0;
        exp_busy  = wr ? (WP_EXP + ((CS_EXP - WP_EXP) < 1 ? 1 : CS_EXP - WP_EXP)) : RD_EXP + 1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=busy expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int falls0;
        repeat (3) @(negedge clk);
        check({req_ready, sram_cs_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, dq_oe, rsp_valid} == 8'b11111100,
              "R1 reset pin state",
              32'({req_ready, sram_cs_n, sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n, dq_oe, rsp_valid}), 32'hFC);
        @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({req_ready, sram_cs_n, sram_we_n, sram_oe_n, dq_oe, rsp_valid} == 6'b111100,
              "R1 first cycle after reset",
              32'({req_ready, sram_cs_n, sram_we_n, sram_oe_n, dq_oe, rsp_valid}), 32'h3C);

        // full word then read back (R2, R3, R5)
        do_op(1, 18'h00010, 16'h1234, 2'b11);
        do_op(0, 18'h00010, 16'h0000, 2'b11);
        // partial writes keep the other byte (R4)
        do_op(1, 18'h00010, 16'hABCD, 2'b01);
        do_op(0, 18'h00010, 16'h0000, 2'b11);
        do_op(1, 18'h00010, 16'h5678, 2'b10);
        do_op(0, 18'h00010, 16'h0000, 2'b11);
        // partial reads mask the disabled lane (R5)
        do_op(0, 18'h00010, 16'h0000, 2'b01);
        do_op(0, 18'h00010, 16'h0000, 2'b10);

        // no enables: no strobe, no change (R9)
        while (!req_ready) @(negedge clk);
        falls0 = cs_falls;
        do_op(1, 18'h00010, 16'hFFFF, 2'b00);
        do_op(0, 18'h00010, 16'h0000, 2'b00);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        check(cs_falls == falls0, "R9 select stayed high", 32'(cs_falls), 32'(falls0));
        do_op(0, 18'h00010, 16'h0000, 2'b11);

        // top of address space, read immediately followed by write (R7)
        do_op(1, 18'h3FFFF, 16'hAAAA, 2'b11);
        do_op(0, 18'h3FFFF, 16'h0000, 2'b11);
        do_op(1, 18'h20000, 16'h0F0F, 2'b11);
        do_op(0, 18'h20000, 16'h0000, 2'b11);

        for (int i = 0; i < 8; i++) begin
            do_op(1, 18'(i * 4099), 16'(i * 16'h1357 + 16'h0101), 2'(i % 3 + 1));
        end
        for (int i = 0; i < 8; i++) begin
            do_op(0, 18'(i * 4099), 16'h0000, 2'b11);
        end

        repeat (30) @(negedge clk);
        check(exp_q.size() == 0, "R5 all responses returned", 32'(exp_q.size()), 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule